// File: doc/BRIEF.md
# PCM Master Clock and Frame Sync Generator

This block is the master-mode timing source of a PCM audio port. It produces the bit clock, the frame sync and a one-cycle frame-start strobe. It runs in the system clock domain and advances only on enable pulses from one of two reference sources. The low-rate source (nominally 4 MHz) drives three preset bit-clock rates at a fixed 8 kHz frame rate. The high-rate source (nominally 48 MHz) drives a programmable rate/limit accumulator and a separate frame-length divider.

Both the clock path and the sync path use one fractional accumulator. On each selected reference tick, a rate value is added to it. When the sum reaches the limit, the limit is subtracted and the bit clock toggles. The frame sequencer counts bit-clock rising edges to place the sync pulse and the frame boundary. Two 32-bit words configure the block: a mode word and a low-jitter word. Both words are sampled only at a frame boundary.

Top module: `pcm_timing_gen`

## Requirements
- R1: While reset is asserted, pcm_clk, pcm_sync and frame_start are 0. After reset, the active mode is the low-rate source, 256 kHz bit clock and long sync.
- R2: With mode bit 11 = 0, the low-rate enable drives the clock. Mode bits [22:21] select the bit clock: 01 gives 128 kHz (16 clocks per frame), 00 gives 256 kHz (32 clocks), 10 gives 512 kHz (64 clocks), and 11 behaves as 00. Every frame lasts exactly 500 low-rate ticks.
- R3: With mode bit 11 = 1, the high-rate enable drives the clock. The limit is low-jitter bits [12:0] and the rate is bits [23:16]. The bit clock frequency is f_ref × rate / (2 × limit). The word 0x08080177 gives 64 clocks per 6000 ticks.
- R4: In high-rate mode, a frame holds 8 × S bit clocks, where S is low-jitter bits [31:24]. S = 0 counts as 256.
- R5: With mode bit 2 = 0 (long sync), pcm_sync is high for the first 8 bit clocks of each frame. Mode bit 12 raises this to 16, but only in high-rate mode; in low-rate mode bit 12 has no effect. The sync stays high for the whole frame when the frame is shorter than the width.
- R6: With mode bit 2 = 1 (short sync), pcm_sync is high for exactly one bit clock, the last of the frame. It falls on the rising edge that starts the next frame.
- R7: With mode bit 8 = 1, pcm_sync stays 0 while pcm_clk and frame_start keep running.
- R8: pcm_sync changes only in the cycle in which pcm_clk rises. frame_start is a one-cycle strobe, given only with the rising edge that opens a frame.
- R9: A change to either configuration word takes effect only at the next frame boundary. The frame in progress keeps its clock count.
- R10: In high-rate mode, a limit of 0 halts pcm_clk low and stops frame_start. While halted, the words are reloaded every cycle, so a valid word restarts the clock at once.
- R11: The accumulator advances only on the enable of the selected source. With rate < limit, it stays below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_ref_en | input | 1 | Tick enable of the low-rate (4 MHz) reference |
| hi_ref_en | input | 1 | Tick enable of the high-rate (48 MHz) reference |
| mode_word | input | 32 | PCM mode word: rate select, source select, sync shape, mute |
| jit_word | input | 32 | Low-jitter word: limit, rate, frame divider |
| pcm_clk | output | 1 | PCM bit clock |
| pcm_sync | output | 1 | PCM frame sync |
| frame_start | output | 1 | One-cycle strobe at each frame's first rising edge |

## Verification
Three things can land on the same system-clock edge: the rising edge that closes a frame, the load of a pending configuration, and the fall of a short sync. The bench provokes this overlap in two ways. It changes the mode word mid-frame, then checks that the old frame keeps its count and that the next frame follows the new word. It also switches between long, short, muted and halted modes, judging each frame by its period in system cycles, its rising-edge count, its sync width and whether sync fell exactly at frame_start. Leaving a halt adds one more overlap: the reload and the first rising edge fall together.

// File: rtl/pcm_timing_pkg.sv
package pcm_timing_pkg;
  localparam int LIM_W    = 13;
  localparam int RATE_W   = 8;
  localparam int SLIM_W   = 8;
  localparam int POS_W    = SLIM_W + 4;
  localparam int LO_LIMIT = 125;
  localparam int LO_RATE_BASE = 8;
  localparam int LO_LEN_BASE  = 16;

  localparam int B_SHORT = 2;
  localparam int B_MUTE  = 8;
  localparam int B_HI    = 11;
  localparam int B_WIDE  = 12;
  localparam int B_RSEL  = 21;

  typedef struct packed {
    logic              hi;
    logic              short_sync;
    logic              wide;
    logic              mute;
    logic [RATE_W-1:0] rate;
    logic [LIM_W-1:0]  limit;
    logic [POS_W-1:0]  flen;
  } pcm_mode_t;

  function automatic pcm_mode_t decode_mode(input logic [31:0] mw,
                                            input logic [31:0] jw);
    pcm_mode_t m;
    logic [SLIM_W-1:0] sl;
    m            = '0;
    sl           = jw[31 -: SLIM_W];
    m.hi         = mw[B_HI];
    m.short_sync = mw[B_SHORT];
    m.mute       = mw[B_MUTE];
    m.wide       = mw[B_HI] & mw[B_WIDE];
    if (mw[B_HI]) begin
      m.rate  = jw[16 +: RATE_W];
      m.limit = jw[LIM_W-1:0];
      m.flen  = (sl == '0) ? POS_W'(1 << (SLIM_W + 3)) : POS_W'({sl, 3'b000});
    end else begin
      m.limit = LIM_W'(LO_LIMIT);
      case (mw[B_RSEL +: 2])
        2'b01:   begin m.rate = RATE_W'(LO_RATE_BASE);     m.flen = POS_W'(LO_LEN_BASE);     end
        2'b10:   begin m.rate = RATE_W'(LO_RATE_BASE * 4); m.flen = POS_W'(LO_LEN_BASE * 4); end
        default: begin m.rate = RATE_W'(LO_RATE_BASE * 2); m.flen = POS_W'(LO_LEN_BASE * 2); end
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/pcm_mode_reg.sv
module pcm_mode_reg
  import pcm_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] mode_word,
  input  logic [31:0] jit_word,
  input  logic        load,
  output pcm_mode_t   act,
  output pcm_mode_t   pend,
  output logic        halted
);
  pcm_mode_t act_q, act_n;

  assign pend   = decode_mode(mode_word, jit_word);
  assign halted = act_q.hi && (act_q.limit == '0);
  assign act    = act_q;

  always_comb begin
    act_n = act_q;
    if (load || halted) act_n = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= decode_mode(32'h0, 32'h0);
    else        act_q <= act_n;
  end

  // R9: the active mode changes only on a boundary load or while halted
  p_load_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ($past(load) || $past(halted)));
endmodule

// File: rtl/pcm_rate_acc.sv
module pcm_rate_acc
  import pcm_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              halted,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  input  logic [LIM_W-1:0]  limit,
  output logic              clk_out,
  output logic              rise
);
  logic [LIM_W-1:0] acc_q, acc_n;
  logic             clk_q, clk_n;
  logic [LIM_W:0]   sum;
  logic             wrap;

  always_comb begin
    sum  = {1'b0, acc_q} + {{(LIM_W + 1 - RATE_W){1'b0}}, rate};
    wrap = tick && !halted && (sum >= {1'b0, limit});
    rise = wrap && !clk_q;
    acc_n = acc_q;
    clk_n = clk_q;
    if (halted) begin
      acc_n = '0;
      clk_n = 1'b0;
    end else if (tick) begin
      acc_n = wrap ? LIM_W'(sum - {1'b0, limit}) : LIM_W'(sum);
      clk_n = wrap ? ~clk_q : clk_q;
      if (restart) acc_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      clk_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      clk_q <= clk_n;
    end
  end

  assign clk_out = clk_q;

  p_halt_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !clk_q);
  p_acc_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && ({1'b0, rate} < {{(RATE_W - LIM_W + 1 > 0 ? 0 : 1){1'b0}}, 1'b0, limit}))
      |-> (acc_q < limit));
  p_idle_no_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !halted) |=> $stable(clk_q));
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
  import pcm_timing_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  input  logic      halted,
  input  pcm_mode_t act,
  input  pcm_mode_t pend,
  output logic      load,
  output logic      sync_out,
  output logic      fs_out
);
  logic [POS_W-1:0] pos_q, pos_n, last, width;
  logic             at_end_q, sync_q, fs_q;
  logic             sync_n;
  pcm_mode_t        sel;

  always_comb begin
    sel   = at_end_q ? pend : act;
    load  = rise && at_end_q;
    last  = sel.flen - POS_W'(1);
    width = sel.wide ? POS_W'(16) : POS_W'(8);
    pos_n = at_end_q ? '0 : pos_q + POS_W'(1);
    if (sel.mute || (sel.hi && sel.limit == '0)) sync_n = 1'b0;
    else if (sel.short_sync)                     sync_n = (pos_n == last);
    else                                         sync_n = (pos_n < width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      at_end_q <= 1'b1;
      sync_q   <= 1'b0;
      fs_q     <= 1'b0;
    end else if (halted) begin
      pos_q    <= '0;
      at_end_q <= 1'b1;
      fs_q     <= 1'b0;
    end else if (rise) begin
      pos_q    <= pos_n;
      at_end_q <= (pos_n == last);
      sync_q   <= sync_n;
      fs_q     <= at_end_q;
    end else begin
      fs_q     <= 1'b0;
    end
  end

  assign sync_out = sync_q;
  assign fs_out   = fs_q;

  p_long_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && !act.short_sync && !act.mute && !halted) |-> sync_q);
  p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act.mute |-> !sync_q);
  p_fs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q);
endmodule

// File: rtl/pcm_timing_gen.sv
module pcm_timing_gen
  import pcm_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_ref_en,
  input  logic        hi_ref_en,
  input  logic [31:0] mode_word,
  input  logic [31:0] jit_word,
  output logic        pcm_clk,
  output logic        pcm_sync,
  output logic        frame_start
);
  pcm_mode_t act, pend;
  logic      halted, load, rise, tick;

  assign tick = act.hi ? hi_ref_en : lo_ref_en;

  pcm_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .jit_word(jit_word),
    .load(load), .act(act), .pend(pend), .halted(halted)
  );

  pcm_rate_acc u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halted(halted), .restart(load),
    .rate(act.rate), .limit(act.limit), .clk_out(pcm_clk), .rise(rise)
  );

  pcm_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rise(rise), .halted(halted), .act(act),
    .pend(pend), .load(load), .sync_out(pcm_sync), .fs_out(frame_start)
  );

  p_sync_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pcm_sync) |-> $rose(pcm_clk));
  p_fs_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $rose(pcm_clk));
  p_short_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pcm_sync) && act.short_sync) |-> frame_start);
endmodule

// File: tb/pcm_timing_gen_bench.sv
module pcm_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lo_ref_en = 1'b0;
  logic        hi_ref_en = 1'b0;
  logic [31:0] mode_word = 32'h0;
  logic [31:0] jit_word = 32'h0;
  logic        pcm_clk, pcm_sync, frame_start;

  int total = 0;
  int bad = 0;
  int lo_div = 1;
  logic p_clk = 1'b0, p_sync = 1'b0;
  logic g_rose = 1'b0, g_sfell = 1'b0;

  always #5 clk = ~clk;

  pcm_timing_gen u_pcm_timing_gen (
    .clk(clk), .rst_n(rst_n), .lo_ref_en(lo_ref_en), .hi_ref_en(hi_ref_en),
    .mode_word(mode_word), .jit_word(jit_word),
    .pcm_clk(pcm_clk), .pcm_sync(pcm_sync), .frame_start(frame_start)
  );

  // cfg, jit, frame period (cycles), rising edges, sync-high edges
  localparam logic [95:0] VEC [0:9] = '{
    {32'h0000_0000, 32'h0000_0000, 16'd500,  8'd32, 8'd8},
    {32'h0020_0000, 32'h0000_0000, 16'd500,  8'd16, 8'd8},
    {32'h0040_0004, 32'h0000_0000, 16'd500,  8'd64, 8'd1},
    {32'h0060_0000, 32'h0000_0000, 16'd500,  8'd32, 8'd8},
    {32'h0000_0800, 32'h0808_0177, 16'd6000, 8'd64, 8'd8},
    {32'h0000_1800, 32'h0808_0177, 16'd6000, 8'd64, 8'd16},
    {32'h0000_0900, 32'h0808_0177, 16'd6000, 8'd64, 8'd0},
    {32'h0000_0804, 32'h0210_0064, 16'd200,  8'd16, 8'd1},
    {32'h0000_1000, 32'h0210_0064, 16'd500,  8'd32, 8'd8},
    {32'h0000_1800, 32'h0110_0064, 16'd100,  8'd8,  8'd8}
  };
  localparam string TAG [0:9] = '{"R1", "R2", "R6", "R2", "R3", "R5", "R7", "R4", "R5", "R5"};

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      hi_ref_en = 1'b1;
      lo_ref_en = (cnt == 0);
      cnt = (cnt + 1 >= lo_div) ? 0 : cnt + 1;
    end
  end

  task automatic chk(input string req, input int actv, input int expv);
    total++;
    if (actv != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    g_rose  = pcm_clk && !p_clk;
    g_sfell = !pcm_sync && p_sync;
    p_clk   = pcm_clk;
    p_sync  = pcm_sync;
  endtask

  task automatic wait_fs();
    do step(); while (!frame_start);
  endtask

  // starts at a frame_start sample, returns at the next one
  task automatic measure(output int per, output int rises, output int syncs,
                         output int fell_end);
    per = 0;
    rises = g_rose ? 1 : 0;
    syncs = (g_rose && pcm_sync) ? 1 : 0;
    forever begin
      step();
      per++;
      if (frame_start) break;
      if (g_rose) begin
        rises++;
        if (pcm_sync) syncs++;
      end
    end
    fell_end = g_sfell ? 1 : 0;
  endtask

  initial begin
    #1900000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, rises, syncs, fell, n, fsn;
    repeat (3) step();
    chk("R1 clk in reset", int'(pcm_clk), 0);
    chk("R1 sync in reset", int'(pcm_sync), 0);
    chk("R1 fs in reset", int'(frame_start), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      mode_word = VEC[i][95:64];
      jit_word  = VEC[i][63:32];
      wait_fs();
      measure(per, rises, syncs, fell);
      chk({TAG[i], " period"}, per, int'(VEC[i][31:16]));
      chk({TAG[i], " rises"}, rises, int'(VEC[i][15:8]));
      chk({TAG[i], " sync width"}, syncs, int'(VEC[i][7:0]));
      chk({TAG[i], " R6 fall at frame start"}, fell, int'(VEC[i][66]));
    end

    // R10: halt with limit 0, then restart at once
    mode_word = 32'h0000_0800;
    jit_word  = 32'h0808_0000;
    wait_fs();
    repeat (5) step();
    n = 0; fsn = 0;
    for (int k = 0; k < 2000; k++) begin
      step();
      if (g_rose) n++;
      if (frame_start) fsn++;
    end
    chk("R10 halted rises", n, 0);
    chk("R10 halted frame starts", fsn, 0);
    chk("R10 halted clk level", int'(pcm_clk), 0);
    jit_word = 32'h0808_0177;
    n = 0;
    do begin step(); n++; end while (!frame_start && n < 200);
    chk("R10 restart latency ok", int'(n < 100), 1);
    measure(per, rises, syncs, fell);
    chk("R10 period after restart", per, 6000);

    // R9: change mid-frame, old frame keeps its count
    mode_word = 32'h0040_0000;
    jit_word  = 32'h0;
    wait_fs();
    rises = 1;
    for (int k = 0; k < 100; k++) begin
      step();
      if (g_rose) rises++;
    end
    mode_word = 32'h0020_0000;
    forever begin
      step();
      if (frame_start) break;
      if (g_rose) rises++;
    end
    chk("R9 old frame rises", rises, 64);
    measure(per, rises, syncs, fell);
    chk("R9 new frame rises", rises, 16);

    // R11: slower low-rate enable, high-rate enable ignored in low-rate mode
    lo_div = 4;
    mode_word = 32'h0;
    wait_fs();
    measure(per, rises, syncs, fell);
    chk("R11 slow tick period", per, 2000);
    chk("R11 slow tick rises", rises, 32);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule